// File: doc/BRIEF.md
# Looping Multi-Channel Pattern Generator

This block feeds a set of parallel output lanes (ten by default, each 28 bits wide) from small on-chip vector memories, one memory per lane. A single shared address counter indexes every memory at once, so all lanes present the word at the same index in the same clock cycle. While the run input is high, the counter steps through every stored word and wraps back to the first with no idle cycle. The lanes therefore replay their stored sequences endlessly and in lockstep. A downstream serializer model takes the lane words together with a word-valid strobe.

A host register port loads the vectors before playback and reads them back to confirm the download. The port has a lane select, a word address, a write-data bus, and separate write and read strobes. Writes take effect only while playback is stopped. A read is answered one clock after its strobe through a registered port, and reads are allowed during playback. Typical vectors include all zeros, all ones, alternating 0xAAAAAAA / 0x5555555 words and incrementing-digit patterns, but any 28-bit value can be stored.

Top module: `pattern_loop_gen`

## Requirements
- R1: After reset, `tx_valid` is 0, `tx_words` is all zeros, `tx_index` is 0 and `host_rvalid` is 0.
- R2: With `run` low, a `host_we` pulse stores `host_wdata` at word `host_addr` of lane `host_sel`. Lane n occupies bits [n*28 +: 28] of `tx_words`.
- R3: A `host_re` pulse makes `host_rvalid` high one clock later, with `host_rdata` holding the stored word of lane `host_sel` at `host_addr`. A select of 10 or above returns zero.
- R4: While `run` is low, the shared counter is held at word 0, `tx_valid` is 0, `tx_index` is 0 and `tx_words` is all zeros, from the first clock edge after `run` falls.
- R5: At the first clock edge with `run` high, the outputs carry word 0 of every lane with `tx_valid` high. Each later edge advances the index by one.
- R6: After word 127 the next cycle carries word 0, with `tx_valid` staying high and no gap.
- R7: In every playback cycle, all lanes carry the word at the same index, and that index is reported on `tx_index`.
- R8: A `host_we` pulse while `run` is high changes no stored word.
- R9: A `host_we` pulse with a select of 10 or above changes no stored word in any lane.
- R10: A host read during playback does not disturb the lane outputs or the index sequence.
- R11: After a stop, raising `run` again restarts playback at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock (53 MHz in the target system) |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Playback enable; low holds the counter at word 0 |
| host_sel | input | 4 | Lane select for host access |
| host_addr | input | 7 | Word address for host access |
| host_wdata | input | 28 | Host write data |
| host_we | input | 1 | Host write strobe (honoured only while stopped) |
| host_re | input | 1 | Host read strobe |
| host_rdata | output | 28 | Registered host read data |
| host_rvalid | output | 1 | High for the cycle after a read strobe |
| tx_words | output | 280 | Lane words, lane n at bits [n*28 +: 28] |
| tx_index | output | 7 | Index of the word now on the lanes |
| tx_valid | output | 1 | Lane words are valid playback data |

## Verification
Host access and playback can fall in the same cycle. A read strobe can arrive while the counter steps, and a write strobe can arrive while `run` is high. The bench issues a read and, later, a refused write in the middle of a 300-cycle run that crosses the wrap point twice. Every lane word and index is compared each cycle against a bench-side model of the memories, and the read data is compared on the following cycle. After the run stops, the word targeted by the refused write is read back and must still hold its original value.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;
  // next playback position with wrap at the memory depth
  function automatic int unsigned pg_next_pos(int unsigned pos, int unsigned depth);
    return (pos + 1 >= depth) ? 0 : pos + 1;
  endfunction

  // lowest bit of a lane inside the flattened output bus
  function automatic int unsigned pg_lane_lo(int unsigned lane, int unsigned width);
    return lane * width;
  endfunction
endpackage

// File: rtl/pg_step_ctr.sv
`timescale 1ns/1ps
module pg_step_ctr #(
  parameter int DEPTH = 128,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  output logic [ADDR_W-1:0] pos_o,
  output logic              wrap_o
);
  import pg_pkg::*;

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] pos_q;

  assign wrap_o = run_i && (pos_q == LAST);
  assign pos_o  = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos_q <= '0;
    else if (!run_i) pos_q <= '0;
    else            pos_q <= ADDR_W'(pg_next_pos(int'(pos_q), DEPTH));
  end

  AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> pos_o == '0); // R4
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !wrap_o |=> pos_o == $past(pos_o) + 1'b1); // R5
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> pos_o == '0); // R6
endmodule

// File: rtl/pg_vec_mem.sv
`timescale 1ns/1ps
module pg_vec_mem #(
  parameter int DEPTH  = 128,
  parameter int WORD_W = 28,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              play_i,
  input  logic [ADDR_W-1:0] play_pos_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] peek_o,
  output logic [WORD_W-1:0] lane_o
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) store[host_addr_i] <= host_wdata_i;
  end

  assign peek_o = store[host_addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lane_o <= '0;
    else if (play_i) lane_o <= store[play_pos_i];
    else             lane_o <= '0;
  end

  AST_NO_WRITE_IN_PLAY: assert property (@(posedge clk) disable iff (!rst_n)
    play_i |-> !wr_en_i); // R8
endmodule

// File: rtl/pattern_loop_gen.sv
`timescale 1ns/1ps
module pattern_loop_gen #(
  parameter int NUM_CH = 10,
  parameter int DEPTH  = 128,
  parameter int WORD_W = 28,
  parameter int SEL_W  = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [SEL_W-1:0]         host_sel,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [WORD_W-1:0]        host_wdata,
  input  logic                     host_we,
  input  logic                     host_re,
  output logic [WORD_W-1:0]        host_rdata,
  output logic                     host_rvalid,
  output logic [NUM_CH*WORD_W-1:0] tx_words,
  output logic [ADDR_W-1:0]        tx_index,
  output logic                     tx_valid
);
  import pg_pkg::*;

  logic [ADDR_W-1:0] play_pos;
  logic              play_wrap;
  logic [NUM_CH-1:0] lane_wr;
  logic [WORD_W-1:0] lane_peek [NUM_CH];
  logic [WORD_W-1:0] peek_sel;
  logic              sel_ok;

  pg_step_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .pos_o  (play_pos),
    .wrap_o (play_wrap)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    assign lane_wr[ch] = host_we && !run && (host_sel == SEL_W'(ch));

    pg_vec_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
      .clk          (clk),
      .rst_n        (rst_n),
      .play_i       (run),
      .play_pos_i   (play_pos),
      .wr_en_i      (lane_wr[ch]),
      .host_addr_i  (host_addr),
      .host_wdata_i (host_wdata),
      .peek_o       (lane_peek[ch]),
      .lane_o       (tx_words[pg_lane_lo(ch, WORD_W) +: WORD_W])
    );
  end

  assign sel_ok = {1'b0, host_sel} < (SEL_W+1)'(NUM_CH);

  always_comb begin
    peek_sel = '0;
    for (int ch = 0; ch < NUM_CH; ch++)
      if (host_sel == SEL_W'(ch)) peek_sel = lane_peek[ch];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_re;
      if (host_re) host_rdata <= sel_ok ? peek_sel : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_index <= '0;
    end else begin
      tx_valid <= run;
      tx_index <= run ? play_pos : '0;
    end
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    host_re |=> host_rvalid); // R3
  AST_VALID_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> tx_valid); // R5
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tx_valid && tx_index == '0 && tx_words == '0); // R4
  AST_NO_GAP_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    play_wrap && run |=> tx_valid && tx_index == ADDR_W'(DEPTH - 1)); // R6
endmodule

// File: tb/test_pattern_loop_gen.sv
`timescale 1ns/1ps
module test_pattern_loop_gen;
  localparam int NCH = 10;
  localparam int DEP = 128;
  localparam int WW  = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [3:0] host_sel = '0;
  logic [6:0] host_addr = '0;
  logic [WW-1:0] host_wdata = '0;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [WW-1:0] host_rdata;
  logic host_rvalid;
  logic [NCH*WW-1:0] tx_words;
  logic [6:0] tx_index;
  logic tx_valid;

  int n_total = 0, n_fail = 0;
  logic [WW-1:0] model [NCH][DEP];

  always #2.5 clk = ~clk;

  pattern_loop_gen i_pattern_loop_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .host_sel(host_sel), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_we(host_we), .host_re(host_re),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .tx_words(tx_words),
    .tx_index(tx_index), .tx_valid(tx_valid)
  );

  function automatic logic [NCH*WW-1:0] exp_lanes(int idx);
    logic [NCH*WW-1:0] v = '0;
    for (int ch = 0; ch < NCH; ch++) v[ch*WW +: WW] = model[ch][idx];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [NCH*WW-1:0] act, logic [NCH*WW-1:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  task automatic host_write(int sel, int addr, logic [WW-1:0] d);
    @(negedge clk);
    host_sel = 4'(sel); host_addr = 7'(addr); host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read_chk(int sel, int addr, logic [WW-1:0] exp, string req);
    @(negedge clk);
    host_sel = 4'(sel); host_addr = 7'(addr); host_re = 1'b1;
    @(negedge clk);
    host_re = 1'b0;
    chk(host_rvalid && host_rdata == exp, req, host_rdata, exp);
  endtask

  initial begin
    #1000000;
    n_total++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int ch = 0; ch < NCH; ch++)
      for (int a = 0; a < DEP; a++)
        case (ch)
          0: model[ch][a] = '0;
          1: model[ch][a] = 28'hFFFFFFF;
          2: model[ch][a] = a[0] ? 28'h5555555 : 28'hAAAAAAA;
          3: model[ch][a] = 28'h1234567 + 28'(a);
          default: model[ch][a] = 28'($urandom);
        endcase

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!tx_valid && tx_words == '0 && tx_index == '0 && !host_rvalid, "R1",
        {tx_valid, tx_index, host_rvalid}, '0);
    rst_n = 1'b1;

    // R2 load every lane while stopped
    for (int ch = 0; ch < NCH; ch++)
      for (int a = 0; a < DEP; a++) host_write(ch, a, model[ch][a]);
    // R2/R3 read back every word
    for (int ch = 0; ch < NCH; ch++)
      for (int a = 0; a < DEP; a++) host_read_chk(ch, a, model[ch][a], "R2_R3 readback");

    // R4 outputs idle while stopped
    @(negedge clk);
    chk(!tx_valid && tx_words == '0 && tx_index == '0, "R4 idle", tx_words, '0);

    // R5 R6 R7 playback across two wraps, with R10 read and R8 write mid-run
    run = 1'b1;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      chk(tx_valid && tx_index == 7'(k % DEP) && tx_words == exp_lanes(k % DEP),
          (k % DEP == 0 && k > 0) ? "R6 wrap" : "R5_R7 playback",
          {tx_valid, tx_index, tx_words}, {1'b1, 7'(k % DEP), exp_lanes(k % DEP)});
      if (k == 50) begin
        host_sel = 4'd5; host_addr = 7'd17; host_re = 1'b1;
      end
      if (k == 51) begin
        host_re = 1'b0;
        chk(host_rvalid && host_rdata == model[5][17], "R10 read in run",
            host_rdata, model[5][17]);
      end
      if (k == 60) begin
        host_sel = 4'd4; host_addr = 7'd61; host_wdata = ~model[4][61]; host_we = 1'b1;
      end
      if (k == 61) host_we = 1'b0;
    end
    run = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!tx_valid && tx_words == '0 && tx_index == '0, "R4 stop", tx_words, '0);
    end

    // R11 restart from word 0
    run = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(tx_valid && tx_index == 7'(k) && tx_words == exp_lanes(k), "R11 restart",
          tx_words, exp_lanes(k));
    end
    run = 1'b0;
    @(negedge clk);

    // R8 write during run refused
    host_read_chk(4, 61, model[4][61], "R8 refused write");

    // R9 out-of-range selects write nothing
    host_write(10, 3, 28'h0BADBAD);
    host_write(15, 3, 28'h0BADBAD);
    host_write(12, 9, 28'h0BADBAD);
    for (int ch = 0; ch < NCH; ch++) begin
      host_read_chk(ch, 3, model[ch][3], "R9 no alias");
      host_read_chk(ch, 9, model[ch][9], "R9 no alias");
    end
    host_read_chk(10, 3, '0, "R3 bad select reads zero");
    host_read_chk(15, 9, '0, "R3 bad select reads zero");

    // R2 overwrite with a random word, then confirm
    begin
      logic [WW-1:0] d = 28'($urandom);
      host_write(7, 127, d);
      model[7][127] = d;
      host_read_chk(7, 127, d, "R2 overwrite");
    end
    finish_up();
  end
endmodule